// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Resolver

This block holds one control register per peripheral interrupt source. Each register has a pending-request bit and a 3-bit priority level. A source raises its request with a single-cycle pulse. On every clock the block searches the pending sources for the one the CPU may take. A source qualifies only when the global enable input is high, its request bit is set, and its level is strictly above the current processor interrupt priority level (IPL). The winner is presented as a registered valid flag together with its source index and level.

When the CPU accepts the presented request with an acknowledge pulse, the block does three things. It clears that source's request bit, saves the old IPL in a one-deep save register, and raises the IPL to the accepted level. A return pulse restores the saved IPL. Software reaches the control registers and the IPL through a simple write port. A request raised by hardware in the same cycle as a software write is never lost.

Top module: `irq_resolver`

## Requirements
- R1: `irq_valid_o` is high only for a source whose request bit was set while `ien_i` was 1 and whose level was strictly greater than the IPL, all as they stood at the previous clock edge.
- R2: A source at level 0 is never presented, and while the IPL is 7 nothing is presented.
- R3: Among the qualifying sources the one with the highest level wins. Among equal levels the lowest source index wins. `irq_src_o` and `irq_lvl_o` carry the winner's index and level.
- R4: The outputs are registered and reflect the register state as it stood before the latest clock edge. After an accepted acknowledge, `irq_valid_o` is low for the next cycle.
- R5: An acknowledge is accepted when `ack_i` is high while `irq_valid_o` is high. It clears the request bit of `irq_src_o`, copies the IPL into the save register, and loads the IPL with `irq_lvl_o`. An `ack_i` while `irq_valid_o` is low has no effect.
- R6: A `ret_i` pulse loads the IPL from the save register, unless an acknowledge is accepted in the same cycle, in which case `ret_i` is ignored.
- R7: A write with `wr_addr_i` below the source count loads that source's register: `wr_data_i[3]` is the request bit and `wr_data_i[2:0]` is the level. A write to address equal to the source count loads the IPL from `wr_data_i[2:0]`, but only when no acknowledge is accepted and no `ret_i` is high in that cycle. Writes to higher addresses are ignored. A write changes no storage other than the one it addresses.
- R8: A `req_set_i` bit sets its request bit, which then stays set until an accepted acknowledge or a write clears it. A set in the same cycle as a clearing write or an acknowledge clear leaves the bit set.
- R9: After reset every request bit, level, the IPL, the save register and `irq_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ien_i | input | 1 | Global maskable interrupt enable |
| req_set_i | input | N_SRC | One-cycle request pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | clog2(N_SRC+1) | Write address: sources, then the IPL |
| wr_data_i | input | 4 | Write data: {request, level[2:0]} |
| ack_i | input | 1 | CPU accepts the presented request |
| ret_i | input | 1 | Return from interrupt, restore saved IPL |
| irq_valid_o | output | 1 | A request is presented |
| irq_src_o | output | clog2(N_SRC) | Index of the presented source |
| irq_lvl_o | output | 3 | Level of the presented source |
| ipl_o | output | 3 | Current processor interrupt priority level |

## Verification
Two things can land on one request bit in the same cycle: a hardware set, and a software write or an acknowledge clear. The bench provokes this in a dedicated phase. It writes a cleared request bit to a source while pulsing that same source's set line. It judges the outcome at the ports: the source must then be presented (or win against a reference model) on the following cycles. Acknowledge, return and IPL writes likewise collide at random, and the IPL output is compared against the model every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 3;
  localparam int LVL_MAX = (1 << LVL_W) - 1;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef struct packed {
    logic req;
    lvl_t lvl;
  } ctl_t;
endpackage

// File: rtl/irq_src_reg.sv
module irq_src_reg
  import irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_hit_i,
  input  ctl_t wr_ctl_i,
  input  logic clr_i,
  input  logic set_i,
  output ctl_t ctl_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else begin
      if (wr_hit_i) ctl_q.lvl <= wr_ctl_i.lvl;
      // hardware set dominates both software write and ack clear
      ctl_q.req <= set_i | (wr_hit_i ? wr_ctl_i.req : (ctl_q.req & ~clr_i));
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  ctl_t [N_SRC-1:0] ctl_i,
  input  logic             ien_i,
  input  lvl_t             ipl_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output lvl_t             lvl_o
);
  logic [N_SRC-1:0] elig;

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    assign elig[g] = ien_i & ctl_i[g].req & (ctl_i[g].lvl > ipl_i);
  end

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    // strict compare keeps the lowest index on ties
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!found_o || ctl_i[i].lvl > lvl_o)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        lvl_o   = ctl_i[i].lvl;
      end
    end
  end
endmodule

// File: rtl/irq_ipl_ctrl.sv
module irq_ipl_ctrl
  import irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  lvl_t fire_lvl_i,
  input  logic ret_i,
  input  logic wr_i,
  input  lvl_t wr_lvl_i,
  output lvl_t ipl_o,
  output lvl_t save_o
);
  lvl_t ipl_q, save_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ipl_q  <= '0;
      save_q <= '0;
    end else if (fire_i) begin
      save_q <= ipl_q;
      ipl_q  <= fire_lvl_i;
    end else if (ret_i) begin
      ipl_q  <= save_q;
    end else if (wr_i) begin
      ipl_q  <= wr_lvl_i;
    end
  end

  assign ipl_o  = ipl_q;
  assign save_o = save_q;
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int AW = $clog2(N_SRC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ien_i,
  input  logic [N_SRC-1:0] req_set_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [LVL_W:0]   wr_data_i,
  input  logic             ack_i,
  input  logic             ret_i,
  output logic             irq_valid_o,
  output logic [IDX_W-1:0] irq_src_o,
  output logic [LVL_W-1:0] irq_lvl_o,
  output logic [LVL_W-1:0] ipl_o
);
  ctl_t [N_SRC-1:0] ctl;
  logic [N_SRC-1:0] req_vec, wr_hit, clr;
  ctl_t             wr_ctl;
  logic             fire, ipl_wr, found;
  logic [IDX_W-1:0] win_idx, src_q;
  lvl_t             win_lvl, lvl_q, ipl_q, save_q;
  logic             valid_q;

  assign wr_ctl = ctl_t'(wr_data_i);
  assign fire   = ack_i & valid_q;
  assign ipl_wr = wr_en_i && (wr_addr_i == AW'(N_SRC));

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign wr_hit[g] = wr_en_i && (wr_addr_i == AW'(g));
    assign clr[g]    = fire && (src_q == IDX_W'(g));

    irq_src_reg u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_hit_i (wr_hit[g]),
      .wr_ctl_i (wr_ctl),
      .clr_i    (clr[g]),
      .set_i    (req_set_i[g]),
      .ctl_o    (ctl[g])
    );

    assign req_vec[g] = ctl[g].req;
  end

  irq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .ctl_i   (ctl),
    .ien_i   (ien_i),
    .ipl_i   (ipl_q),
    .found_o (found),
    .idx_o   (win_idx),
    .lvl_o   (win_lvl)
  );

  irq_ipl_ctrl u_ipl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .fire_lvl_i (lvl_q),
    .ret_i      (ret_i),
    .wr_i       (ipl_wr),
    .wr_lvl_i   (wr_ctl.lvl),
    .ipl_o      (ipl_q),
    .save_o     (save_q)
  );

  // drop valid right after an accepted ack; state catches up one edge later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      src_q   <= '0;
      lvl_q   <= '0;
    end else begin
      valid_q <= found & ~fire;
      src_q   <= win_idx;
      lvl_q   <= win_lvl;
    end
  end

  assign irq_valid_o = valid_q;
  assign irq_src_o   = src_q;
  assign irq_lvl_o   = lvl_q;
  assign ipl_o       = ipl_q;
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int AW = $clog2(N_SRC + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ien_i,
  input logic [N_SRC-1:0] req_set_i,
  input logic             wr_en_i,
  input logic [AW-1:0]    wr_addr_i,
  input logic             ack_i,
  input logic             ret_i,
  input logic             irq_valid_o,
  input logic [IDX_W-1:0] irq_src_o,
  input logic [LVL_W-1:0] irq_lvl_o,
  input logic [LVL_W-1:0] ipl_o,
  input logic [N_SRC-1:0] req_vec_i,
  input logic [LVL_W-1:0] save_i
);
  p_elig_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> ($past(ien_i) && irq_lvl_o > $past(ipl_o)));

  p_no_lvl0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (irq_lvl_o != '0 && $past(ipl_o) != LVL_W'(LVL_MAX)));

  p_src_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (32'(irq_src_o) < N_SRC));

  p_drop_after_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_valid_o) |=> !irq_valid_o);

  p_ack_raise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_valid_o) |=> (ipl_o == $past(irq_lvl_o) && save_i == $past(ipl_o)));

  p_ret_restore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !(ack_i && irq_valid_o)) |=> (ipl_o == $past(save_i)));

  p_ipl_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(ack_i && irq_valid_o) && !ret_i && !(wr_en_i && wr_addr_i == AW'(N_SRC)))
    |=> $stable(ipl_o));

  for (genvar g = 0; g < N_SRC; g++) begin : g_set
    p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_set_i[g] |=> req_vec_i[g]);
  end
endmodule

bind irq_resolver irq_resolver_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ien_i       (ien_i),
  .req_set_i   (req_set_i),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .ack_i       (ack_i),
  .ret_i       (ret_i),
  .irq_valid_o (irq_valid_o),
  .irq_src_o   (irq_src_o),
  .irq_lvl_o   (irq_lvl_o),
  .ipl_o       (ipl_o),
  .req_vec_i   (req_vec),
  .save_i      (save_q)
);

// File: tb/tb_irq_resolver.sv
`timescale 1ns/1ps
module tb_irq_resolver;
  localparam int N  = 8;
  localparam int AW = $clog2(N + 1);
  localparam int IW = $clog2(N);
  localparam int PH_LEN = 500;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ien = 1'b0;
  logic [N-1:0]  req_set = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [3:0]    wr_data = '0;
  logic          ack = 1'b0;
  logic          ret = 1'b0;
  logic          irq_valid;
  logic [IW-1:0] irq_src;
  logic [2:0]    irq_lvl;
  logic [2:0]    ipl;

  irq_resolver #(.N_SRC(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ien_i(ien), .req_set_i(req_set),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ack_i(ack), .ret_i(ret), .irq_valid_o(irq_valid), .irq_src_o(irq_src),
    .irq_lvl_o(irq_lvl), .ipl_o(ipl)
  );

  always #2 clk = ~clk;

  // reference model state
  int m_req[N];
  int m_lvl[N];
  int m_ipl, m_sav, m_ov, m_os, m_ol;
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock of the reference, using the inputs now on the pins
  task automatic model_step();
    int bv = 0, bs = 0, bl = 0;
    bit fire;
    fire = ack && (m_ov != 0);
    for (int i = 0; i < N; i++)
      if (ien && m_req[i] != 0 && m_lvl[i] > m_ipl && (bv == 0 || m_lvl[i] > bl)) begin
        bv = 1; bs = i; bl = m_lvl[i];
      end
    for (int i = 0; i < N; i++) begin
      if (wr_en && int'(wr_addr) == i) begin
        m_req[i] = int'(wr_data[3]);
        m_lvl[i] = int'(wr_data[2:0]);
      end else if (fire && m_os == i) begin
        m_req[i] = 0;
      end
      if (req_set[i]) m_req[i] = 1;
    end
    if (fire) begin
      m_sav = m_ipl;
      m_ipl = m_ol;
    end else if (ret) begin
      m_ipl = m_sav;
    end else if (wr_en && int'(wr_addr) == N) begin
      m_ipl = int'(wr_data[2:0]);
    end
    m_ov = (bv != 0 && !fire) ? 1 : 0;
    m_os = bs;
    m_ol = bl;
  endtask

  // phases: 0 general R4, 1 enable R1, 2 level0/IPL7 R2, 3 ties R3,
  // 4 collision R8, 5 return R6, 6 write decode R7
  task automatic drive(int ph);
    int k;
    ien     = (ph == 1) ? 1'($urandom % 2) : 1'(($urandom % 10) != 0);
    req_set = N'($urandom & $urandom & $urandom);
    ack     = 1'(($urandom % 3) == 0);
    ret     = 1'(($urandom % ((ph == 5) ? 3 : 9)) == 0);
    wr_en   = 1'(($urandom % 4) == 0);
    wr_addr = AW'($urandom % (N + 1));
    wr_data = 4'($urandom);
    case (ph)
      2: begin
        if ($urandom % 2 != 0) wr_data[2:0] = 3'd0;
        if ($urandom % 5 == 0) begin
          wr_en = 1'b1; wr_addr = AW'(N); wr_data = 4'd7; ack = 1'b0; ret = 1'b0;
        end
      end
      3: begin
        wr_data[2:0] = 3'd5;
        if ($urandom % 6 == 0) begin
          wr_addr = AW'(N); wr_data = 4'd0;
        end
      end
      4: begin
        k = int'($urandom % N);
        wr_en = 1'b1; wr_addr = AW'(k);
        wr_data = {1'b0, 3'(1 + $urandom % 7)};
        req_set[k] = 1'b1;
        if ($urandom % 4 == 0) begin
          wr_addr = AW'(N); wr_data = 4'd0;
        end
      end
      6: wr_addr = AW'($urandom);
      default: ;
    endcase
  endtask

  task automatic compare(int ph);
    string vt, it;
    case (ph)
      1: vt = "R1"; 2: vt = "R2"; 3: vt = "R3";
      4: vt = "R8"; 5: vt = "R6"; 6: vt = "R7";
      default: vt = "R4";
    endcase
    it = (ph == 5) ? "R6" : (ph == 6) ? "R7" : "R5";
    chk(int'(irq_valid) == m_ov, vt, "irq_valid", int'(irq_valid), m_ov);
    if (m_ov != 0 && irq_valid) begin
      chk(int'(irq_src) == m_os, "R3", "irq_src", int'(irq_src), m_os);
      chk(int'(irq_lvl) == m_ol, "R3", "irq_lvl", int'(irq_lvl), m_ol);
    end
    chk(int'(ipl) == m_ipl, it, "ipl", int'(ipl), m_ipl);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_req[i] = 0; m_lvl[i] = 0;
    end
    m_ipl = 0; m_sav = 0; m_ov = 0; m_os = 0; m_ol = 0;
    repeat (3) @(negedge clk);
    chk(irq_valid == 1'b0, "R9", "reset irq_valid", int'(irq_valid), 0);
    chk(ipl == 3'd0, "R9", "reset ipl", int'(ipl), 0);
    // set req bits via pulses while enabled: nothing at level 0 after reset
    rst_n = 1'b1;
    ien = 1'b1;
    req_set = '1;
    model_step();
    @(negedge clk);
    compare(2);
    req_set = '0;
    model_step();
    @(negedge clk);
    chk(irq_valid == 1'b0, "R9", "reset levels zero", int'(irq_valid), 0);
    compare(2);
    for (int ph = 0; ph < 7; ph++) begin
      for (int c = 0; c < PH_LEN; c++) begin
        drive(ph);
        model_step();
        @(negedge clk);
        compare(ph);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule